// File: doc/BRIEF.md
# Sliding-Window RC4 Key Scanner

This block hunts for a 128-bit RC4 key hidden somewhere inside a captured byte stream. The captured bytes sit in an on-chip capture buffer and a block of ciphertext sits in a second buffer; both are loaded through simple write ports. A scan begins with a start strobe. A 16-byte window then steps one byte at a time over the capture buffer. Each window position is used as a trial key. The block runs the RC4 key schedule with that key, decrypts the whole ciphertext block, and builds a histogram of the resulting bytes.

A wrong key yields output that looks like noise, so its histogram stays flat. The right key usually yields plaintext with one byte value repeated many times. The score of a candidate is the height of the tallest histogram bin. A candidate whose score is above a programmable threshold is flagged. As an optional second test, a 32-bit word at a programmable position in the plaintext can be required to equal a programmable value. The block keeps the first flagged window offset and also the best score seen with its offset. It raises a one-cycle done pulse when the scan ends.

Top module: `rc4_key_scanner`

## Requirements
- R1: After reset, busy, done and matchFound are 0, and matchOffset, bestScore and bestOffset are 0.
- R2: The candidate at window offset o uses key byte k = capture[(o+k) mod CAP_DEPTH] for k = 0..15. The state is set to the identity permutation, then one swap per i = 0..255 with j += S[i] + key[i mod 16]. Output byte b (b = 0..CT_LEN-1) is produced by i += 1, j += S[i], swap S[i] and S[j], then S[S[i]+S[j]] XOR ciphertext[b].
- R3: A candidate's score is the number of times the most frequent value occurs among its CT_LEN output bytes. The histogram is counted afresh for every candidate. bestScore and bestOffset report the highest score of the scan and where it occurred; on a tie the earlier candidate is kept.
- R4: A candidate is flagged only when its score is strictly greater than threshold and the magic test (R5) passes. matchFound and matchOffset report the first flagged candidate in scan order.
- R5: When magicEn is 1, output bytes magicOffset..magicOffset+3 form a word with byte magicOffset in bits 7:0 and byte magicOffset+3 in bits 31:24, and this word must equal magicWord. magicOffset must not exceed CT_LEN-4. When magicEn is 0 the magic test always passes.
- R6: A scan with start offset s and count N tries the offsets s, s+1, …, s+N-1 in that order, each taken modulo CAP_DEPTH.
- R7: Count the edge that accepts start as edge 0. done is high for exactly one cycle, and that cycle begins at edge N*(513+2*CT_LEN). With N = 0 the cycle begins at edge 0. busy is high from edge 0 through the done cycle.
- R8: The start offset, count, threshold and magic settings are captured when start is accepted. While busy, a start strobe and any change to these inputs have no effect on the running scan.
- R9: The result outputs keep their values after done until the next accepted start, which clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Starts a scan when idle |
| startOffset | input | CAP_AW | First window offset |
| numCand | input | CAP_AW+1 | Number of candidates to try |
| threshold | input | HW | A score must exceed this value |
| magicEn | input | 1 | Enables the magic-word test |
| magicWord | input | 32 | Expected magic word |
| magicOffset | input | CT_AW | Plaintext byte position of the magic word |
| capWrEn | input | 1 | Capture buffer write enable |
| capWrAddr | input | CAP_AW | Capture buffer write address |
| capWrData | input | 8 | Capture buffer write data |
| ctWrEn | input | 1 | Ciphertext buffer write enable |
| ctWrAddr | input | CT_AW | Ciphertext buffer write address |
| ctWrData | input | 8 | Ciphertext buffer write data |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| matchFound | output | 1 | At least one candidate was flagged |
| matchOffset | output | CAP_AW | Offset of the first flagged candidate |
| bestScore | output | HW | Highest score of the scan |
| bestOffset | output | CAP_AW | Offset that reached bestScore |

## Verification
The capture buffer holds two copies of one key among filler bytes. A single scan across both copies shows whether the first-match rule and the earliest-on-tie rule hold, and whether the histogram is cleared between candidates, because the scores of the many wrong windows must match the model exactly. The magic word is tried with the true value and with a value that differs in one bit. The threshold is set both equal to the right key's score and one below it, which separates a strict compare from a non-strict one. A key that wraps past the end of the buffer, a scan with zero candidates, and a restart attempt with changed settings in the middle of a scan cover the window arithmetic, the timing rule and the latching of settings.

// File: rtl/rc4scan_pkg.sv
package rc4scan_pkg;

  // RC4 state size is fixed by the cipher
  localparam int SBOX_N = 256;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_KSA,
    ST_GEN_A,
    ST_GEN_B,
    ST_SCORE,
    ST_DONE
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       scanStart;  // start accepted: latch config, clear results
    logic       initStep;   // identity fill of S, clear of histogram
    logic       ksaStep;    // one key-schedule swap
    logic       genSwap;    // output phase: advance i/j and swap
    logic       genOut;     // output phase: emit byte, bump histogram
    logic       scoreStep;  // judge finished candidate
    logic [7:0] idx;        // step index for init and key schedule
  } scanCtl_t;

endpackage

// File: rtl/rc4scan_ctrl.sv
module rc4scan_ctrl
  import rc4scan_pkg::*;
#(
  parameter int CAP_AW = 6,
  parameter int CT_LEN = 32,
  localparam int CT_AW = $clog2(CT_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CAP_AW-1:0] startOffset,
  input  logic [CAP_AW:0]   numCand,
  output scanCtl_t          ctl,
  output logic [CT_AW-1:0]  byteIdx,
  output logic [CAP_AW-1:0] candOffset,
  output logic              busy,
  output logic              done
);

  localparam logic [7:0] LAST_STEP = 8'(SBOX_N - 1);
  localparam logic [7:0] LAST_BYTE = 8'(CT_LEN - 1);

  scanState_t        state;
  logic [7:0]        stepCnt;
  logic [CAP_AW:0]   candLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      stepCnt    <= '0;
      candOffset <= '0;
      candLeft   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            candOffset <= startOffset;
            candLeft   <= numCand;
            stepCnt    <= '0;
            state      <= (numCand == '0) ? ST_DONE : ST_INIT;
          end
        end
        ST_INIT: begin
          stepCnt <= stepCnt + 8'd1;
          if (stepCnt == LAST_STEP) state <= ST_KSA;
        end
        ST_KSA: begin
          stepCnt <= stepCnt + 8'd1;
          if (stepCnt == LAST_STEP) state <= ST_GEN_A;
        end
        ST_GEN_A: state <= ST_GEN_B;
        ST_GEN_B: begin
          if (stepCnt == LAST_BYTE) begin
            stepCnt <= '0;
            state   <= ST_SCORE;
          end else begin
            stepCnt <= stepCnt + 8'd1;
            state   <= ST_GEN_A;
          end
        end
        ST_SCORE: begin
          if (candLeft == 1) begin
            state <= ST_DONE;
          end else begin
            candLeft   <= candLeft - 1'b1;
            candOffset <= candOffset + 1'b1;
            state      <= ST_INIT;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.scanStart = (state == ST_IDLE) && start;
    ctl.initStep  = (state == ST_INIT);
    ctl.ksaStep   = (state == ST_KSA);
    ctl.genSwap   = (state == ST_GEN_A);
    ctl.genOut    = (state == ST_GEN_B);
    ctl.scoreStep = (state == ST_SCORE);
    ctl.idx       = stepCnt;
  end

  assign byteIdx = stepCnt[CT_AW-1:0];
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.initStep, ctl.ksaStep, ctl.genSwap, ctl.genOut, ctl.scoreStep}));

  // R6
  window_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.scoreStep && candLeft != 1) |=> candOffset == $past(candOffset) + 1'b1);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.initStep || ctl.ksaStep) |=> $stable(candOffset) && $stable(candLeft));

endmodule

// File: rtl/rc4scan_datapath.sv
module rc4scan_datapath
  import rc4scan_pkg::*;
#(
  parameter int CAP_DEPTH = 64,
  parameter int CT_LEN    = 32,
  parameter int KEY_BYTES = 16,
  parameter bit HAS_MAGIC = 1'b1,
  localparam int CAP_AW = $clog2(CAP_DEPTH),
  localparam int CT_AW  = $clog2(CT_LEN),
  localparam int HW     = $clog2(CT_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanCtl_t          ctl,
  input  logic [CT_AW-1:0]  byteIdx,
  input  logic [CAP_AW-1:0] candOffset,
  input  logic [HW-1:0]     threshold,
  input  logic              magicEn,
  input  logic [31:0]       magicWord,
  input  logic [CT_AW-1:0]  magicOffset,
  input  logic              capWrEn,
  input  logic [CAP_AW-1:0] capWrAddr,
  input  logic [7:0]        capWrData,
  input  logic              ctWrEn,
  input  logic [CT_AW-1:0]  ctWrAddr,
  input  logic [7:0]        ctWrData,
  output logic              matchFound,
  output logic [CAP_AW-1:0] matchOffset,
  output logic [HW-1:0]     bestScore,
  output logic [CAP_AW-1:0] bestOffset
);

  // storage
  logic [7:0]    capMem [CAP_DEPTH];
  logic [7:0]    ctMem  [CT_LEN];
  logic [7:0]    sMem   [SBOX_N];
  logic [HW-1:0] hist   [SBOX_N];

  logic [7:0]        iReg, jReg;
  logic [HW-1:0]     maxCount;
  logic [HW-1:0]     thrLat;
  logic              magicOk;

  logic [CAP_AW-1:0] keyPos;
  logic [7:0]        keyByte, ksaJ, genI, genJ, tIdx, ptByte;
  logic [HW-1:0]     histNext;

  // window byte for the current key-schedule step
  assign keyPos  = CAP_AW'(ctl.idx % 8'(KEY_BYTES));
  assign keyByte = capMem[candOffset + keyPos];
  assign ksaJ    = jReg + sMem[ctl.idx] + keyByte;

  // output phase
  assign genI     = iReg + 8'd1;
  assign genJ     = jReg + sMem[genI];
  assign tIdx     = sMem[iReg] + sMem[jReg];
  assign ptByte   = sMem[tIdx] ^ ctMem[byteIdx];
  assign histNext = hist[ptByte] + 1'b1;

  always_ff @(posedge clk) begin
    if (capWrEn) capMem[capWrAddr] <= capWrData;
    if (ctWrEn)  ctMem[ctWrAddr]   <= ctWrData;
  end

  always_ff @(posedge clk) begin
    if (ctl.initStep) begin
      sMem[ctl.idx] <= ctl.idx;
    end else if (ctl.ksaStep) begin
      sMem[ctl.idx] <= sMem[ksaJ];
      sMem[ksaJ]    <= sMem[ctl.idx];
    end else if (ctl.genSwap) begin
      sMem[genI] <= sMem[genJ];
      sMem[genJ] <= sMem[genI];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.initStep)    hist[ctl.idx] <= '0;
    else if (ctl.genOut) hist[ptByte]  <= histNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iReg        <= '0;
      jReg        <= '0;
      maxCount    <= '0;
      thrLat      <= '0;
      matchFound  <= 1'b0;
      matchOffset <= '0;
      bestScore   <= '0;
      bestOffset  <= '0;
    end else begin
      if (ctl.scanStart) begin
        thrLat      <= threshold;
        matchFound  <= 1'b0;
        matchOffset <= '0;
        bestScore   <= '0;
        bestOffset  <= '0;
      end
      if (ctl.initStep) begin
        iReg     <= '0;
        jReg     <= '0;
        maxCount <= '0;
      end
      if (ctl.ksaStep) jReg <= (ctl.idx == 8'hFF) ? 8'd0 : ksaJ;
      if (ctl.genSwap) begin
        iReg <= genI;
        jReg <= genJ;
      end
      if (ctl.genOut && histNext > maxCount) maxCount <= histNext;
      if (ctl.scoreStep) begin
        if (maxCount > thrLat && magicOk && !matchFound) begin
          matchFound  <= 1'b1;
          matchOffset <= candOffset;
        end
        if (maxCount > bestScore) begin
          bestScore  <= maxCount;
          bestOffset <= candOffset;
        end
      end
    end
  end

  generate
    if (HAS_MAGIC) begin : g_magic
      logic              magEnLat;
      logic [31:0]       magWordLat;
      logic [CT_AW-1:0]  magOffLat;
      logic [31:0]       magCap;
      logic [CT_AW-1:0]  magDiff;

      assign magDiff = byteIdx - magOffLat;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          magEnLat   <= 1'b0;
          magWordLat <= '0;
          magOffLat  <= '0;
          magCap     <= '0;
        end else begin
          if (ctl.scanStart) begin
            magEnLat   <= magicEn;
            magWordLat <= magicWord;
            magOffLat  <= magicOffset;
          end
          if (ctl.genOut && (32'(magDiff) < 4))
            magCap[{magDiff[1:0], 3'b000} +: 8] <= ptByte;
        end
      end

      assign magicOk = !magEnLat || (magCap == magWordLat);
    end else begin : g_nomagic
      assign magicOk = 1'b1;
    end
  endgenerate

  // R3
  best_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.scanStart |=> bestScore >= $past(bestScore));

  // R3
  score_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    maxCount <= HW'(CT_LEN));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.scanStart || ctl.scoreStep) |=> $stable(matchFound) && $stable(matchOffset)
      && $stable(bestScore) && $stable(bestOffset));

  // R4
  match_threshold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFound) |-> maxCount > thrLat);

endmodule

// File: rtl/rc4_key_scanner.sv
module rc4_key_scanner
  import rc4scan_pkg::*;
#(
  parameter int CAP_DEPTH = 64,
  parameter int CT_LEN    = 32,
  parameter int KEY_BYTES = 16,
  parameter bit HAS_MAGIC = 1'b1,
  localparam int CAP_AW = $clog2(CAP_DEPTH),
  localparam int CT_AW  = $clog2(CT_LEN),
  localparam int HW     = $clog2(CT_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CAP_AW-1:0] startOffset,
  input  logic [CAP_AW:0]   numCand,
  input  logic [HW-1:0]     threshold,
  input  logic              magicEn,
  input  logic [31:0]       magicWord,
  input  logic [CT_AW-1:0]  magicOffset,
  input  logic              capWrEn,
  input  logic [CAP_AW-1:0] capWrAddr,
  input  logic [7:0]        capWrData,
  input  logic              ctWrEn,
  input  logic [CT_AW-1:0]  ctWrAddr,
  input  logic [7:0]        ctWrData,
  output logic              busy,
  output logic              done,
  output logic              matchFound,
  output logic [CAP_AW-1:0] matchOffset,
  output logic [HW-1:0]     bestScore,
  output logic [CAP_AW-1:0] bestOffset
);

  scanCtl_t          ctl;
  logic [CT_AW-1:0]  byteIdx;
  logic [CAP_AW-1:0] candOffset;

  rc4scan_ctrl #(
    .CAP_AW (CAP_AW),
    .CT_LEN (CT_LEN)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .startOffset (startOffset),
    .numCand     (numCand),
    .ctl         (ctl),
    .byteIdx     (byteIdx),
    .candOffset  (candOffset),
    .busy        (busy),
    .done        (done)
  );

  rc4scan_datapath #(
    .CAP_DEPTH (CAP_DEPTH),
    .CT_LEN    (CT_LEN),
    .KEY_BYTES (KEY_BYTES),
    .HAS_MAGIC (HAS_MAGIC)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .byteIdx     (byteIdx),
    .candOffset  (candOffset),
    .threshold   (threshold),
    .magicEn     (magicEn),
    .magicWord   (magicWord),
    .magicOffset (magicOffset),
    .capWrEn     (capWrEn),
    .capWrAddr   (capWrAddr),
    .capWrData   (capWrData),
    .ctWrEn      (ctWrEn),
    .ctWrAddr    (ctWrAddr),
    .ctWrData    (ctWrData),
    .matchFound  (matchFound),
    .matchOffset (matchOffset),
    .bestScore   (bestScore),
    .bestOffset  (bestOffset)
  );

endmodule

// File: tb/rc4_key_scanner_tb_top.sv
`timescale 1ns/1ps
module rc4_key_scanner_tb_top;

  localparam int CAP_DEPTH = 64;
  localparam int CT_LEN    = 32;
  localparam int CAP_AW    = 6;
  localparam int CT_AW     = 5;
  localparam int HW        = 6;
  localparam int CAND_CYC  = 513 + 2 * CT_LEN;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [CAP_AW-1:0] startOffset = '0;
  logic [CAP_AW:0]   numCand = '0;
  logic [HW-1:0]     threshold = '0;
  logic              magicEn = 1'b0;
  logic [31:0]       magicWord = '0;
  logic [CT_AW-1:0]  magicOffset = '0;
  logic              capWrEn = 1'b0;
  logic [CAP_AW-1:0] capWrAddr = '0;
  logic [7:0]        capWrData = '0;
  logic              ctWrEn = 1'b0;
  logic [CT_AW-1:0]  ctWrAddr = '0;
  logic [7:0]        ctWrData = '0;
  logic              busy, done, matchFound;
  logic [CAP_AW-1:0] matchOffset, bestOffset;
  logic [HW-1:0]     bestScore;

  always #2.5 clk = ~clk;

  rc4_key_scanner dut_i (
    .clk(clk), .rstN(rstN), .start(start), .startOffset(startOffset),
    .numCand(numCand), .threshold(threshold), .magicEn(magicEn),
    .magicWord(magicWord), .magicOffset(magicOffset),
    .capWrEn(capWrEn), .capWrAddr(capWrAddr), .capWrData(capWrData),
    .ctWrEn(ctWrEn), .ctWrAddr(ctWrAddr), .ctWrData(ctWrData),
    .busy(busy), .done(done), .matchFound(matchFound),
    .matchOffset(matchOffset), .bestScore(bestScore), .bestOffset(bestOffset)
  );

  int checks = 0;
  int fails = 0;
  int cycleCnt = 0;
  int acceptCycle = 0;
  int resolved = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  typedef struct {
    int found;
    int mOff;
    int best;
    int bOff;
    int lat;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];

  logic [7:0] capModel [CAP_DEPTH];
  logic [7:0] ctModel  [CT_LEN];
  logic [7:0] ptModel  [CT_LEN];
  logic [7:0] plantKey [16];
  int         keyArr   [16];
  logic [7:0] ksArr    [CT_LEN];

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference RC4 from the requirement text (R2)
  function automatic void rc4Keystream();
    int s [256];
    int i, j, t, tmp;
    for (int k = 0; k < 256; k++) s[k] = k;
    j = 0;
    for (int k = 0; k < 256; k++) begin
      j = (j + s[k] + keyArr[k % 16]) % 256;
      tmp = s[k]; s[k] = s[j]; s[j] = tmp;
    end
    i = 0; j = 0;
    for (int b = 0; b < CT_LEN; b++) begin
      i = (i + 1) % 256;
      j = (j + s[i]) % 256;
      tmp = s[i]; s[i] = s[j]; s[j] = tmp;
      t = (s[i] + s[j]) % 256;
      ksArr[b] = 8'(s[t]);
    end
  endfunction

  // score and magic word of one candidate (R3, R5)
  function automatic void scoreCand(input int off, input int mo, output int score,
                                    output logic [31:0] mg);
    int hist [256];
    int p;
    for (int k = 0; k < 16; k++) keyArr[k] = int'(capModel[(off + k) % CAP_DEPTH]);
    rc4Keystream();
    for (int h = 0; h < 256; h++) hist[h] = 0;
    score = 0;
    mg = '0;
    for (int b = 0; b < CT_LEN; b++) begin
      p = int'(ksArr[b] ^ ctModel[b]);
      hist[p]++;
      if (hist[p] > score) score = hist[p];
      if (b >= mo && b < mo + 4) mg[(b - mo) * 8 +: 8] = 8'(p);
    end
  endfunction

  task automatic loadCap();
    for (int a = 0; a < CAP_DEPTH; a++) begin
      @(negedge clk);
      capWrEn = 1'b1; capWrAddr = CAP_AW'(a); capWrData = capModel[a];
    end
    @(negedge clk);
    capWrEn = 1'b0;
  endtask

  task automatic loadCt();
    for (int a = 0; a < CT_LEN; a++) begin
      @(negedge clk);
      ctWrEn = 1'b1; ctWrAddr = CT_AW'(a); ctWrData = ctModel[a];
    end
    @(negedge clk);
    ctWrEn = 1'b0;
  endtask

  // driver: compute expectation, push it, start the scan
  task automatic runScan(input int off, input int n, input int thr, input bit me,
                         input logic [31:0] mw, input int mo, input bit poke,
                         input string tag);
    exp_t e;
    int sc;
    logic [31:0] mg;
    int target;
    e.found = 0; e.mOff = 0; e.best = 0; e.bOff = 0; e.lat = n * CAND_CYC;
    for (int c = 0; c < n; c++) begin
      int o;
      o = (off + c) % CAP_DEPTH;
      scoreCand(o, mo, sc, mg);
      if (sc > thr && (!me || mg == mw) && e.found == 0) begin
        e.found = 1; e.mOff = o;
      end
      if (sc > e.best) begin
        e.best = sc; e.bOff = o;
      end
    end
    expQ.push_back(e);
    tagQ.push_back(tag);
    target = resolved + 1;
    @(negedge clk);
    startOffset = CAP_AW'(off); numCand = (CAP_AW + 1)'(n); threshold = HW'(thr);
    magicEn = me; magicWord = mw; magicOffset = CT_AW'(mo); start = 1'b1;
    @(posedge clk);
    #1 acceptCycle = cycleCnt;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R8: restart attempt with different settings mid-scan
      repeat (300) @(negedge clk);
      start = 1'b1; startOffset = '0; numCand = 1; threshold = '0; magicEn = 1'b0;
      @(negedge clk);
      start = 1'b0;
    end
    wait (resolved == target);
  endtask

  // monitor: pop and compare on each done pulse
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN && done) begin
        exp_t e;
        string tg;
        if (expQ.size() == 0) begin
          chkEq("R7", "unexpected done", 1, 0);
        end else begin
          e = expQ.pop_front();
          tg = tagQ.pop_front();
          chkEq({"R4 ", tg}, "matchFound", int'(matchFound), e.found);
          chkEq({"R4 ", tg}, "matchOffset", int'(matchOffset), e.mOff);
          chkEq({"R3 ", tg}, "bestScore", int'(bestScore), e.best);
          chkEq({"R3 ", tg}, "bestOffset", int'(bestOffset), e.bOff);
          chkEq({"R7 ", tg}, "done latency", cycleCnt - acceptCycle, e.lat);
          chkEq("R7", "busy during done", int'(busy), 1);
          repeat (3) @(posedge clk);
          #2;
          chkEq("R7", "done single cycle", int'(done), 0);
          chkEq("R9", "busy low after done", int'(busy), 0);
          chkEq("R9", "matchFound held", int'(matchFound), e.found);
          chkEq("R9", "matchOffset held", int'(matchOffset), e.mOff);
          chkEq("R9", "bestScore held", int'(bestScore), e.best);
          resolved++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chkEq("R1", "busy", int'(busy), 0);
    chkEq("R1", "done", int'(done), 0);
    chkEq("R1", "matchFound", int'(matchFound), 0);
    chkEq("R1", "matchOffset", int'(matchOffset), 0);
    chkEq("R1", "bestScore", int'(bestScore), 0);
    chkEq("R1", "bestOffset", int'(bestOffset), 0);

    for (int a = 0; a < CAP_DEPTH; a++) capModel[a] = 8'((a * 73 + 29) ^ (a >> 1));
    for (int k = 0; k < 16; k++) plantKey[k] = 8'(k * 29 + 8'h5A);
    for (int k = 0; k < 16; k++) begin
      capModel[20 + k] = plantKey[k];
      capModel[40 + k] = plantKey[k];
    end
    for (int b = 0; b < CT_LEN; b++) ptModel[b] = 8'h41;
    ptModel[28] = 8'hEF; ptModel[29] = 8'hBE; ptModel[30] = 8'hAD; ptModel[31] = 8'hDE;
    for (int k = 0; k < 16; k++) keyArr[k] = int'(plantKey[k]);
    rc4Keystream();
    for (int b = 0; b < CT_LEN; b++) ctModel[b] = ptModel[b] ^ ksArr[b];
    loadCap();
    loadCt();

    // R2 R6 R3: two copies of the key, first match and earliest tie
    runScan(18, 24, 8, 1'b0, 32'h0, 0, 1'b0, "R2 R6 twin keys");
    // R5: magic word differs in one bit
    runScan(19, 3, 8, 1'b1, 32'hDEADBEEE, 28, 1'b0, "R5 wrong magic");
    // R5: correct little-endian magic word
    runScan(19, 3, 8, 1'b1, 32'hDEADBEEF, 28, 1'b0, "R5 right magic");
    // R4: threshold equal to score is not enough
    runScan(20, 1, 28, 1'b0, 32'h0, 0, 1'b0, "R4 threshold equal");
    runScan(20, 1, 27, 1'b0, 32'h0, 0, 1'b0, "R4 threshold below");
    // R8: start and settings changed while busy
    runScan(17, 5, 8, 1'b0, 32'h0, 0, 1'b1, "R8 restart ignored");
    // R7: zero candidates
    runScan(20, 0, 8, 1'b0, 32'h0, 0, 1'b0, "R7 zero candidates");

    // R6: key wrapping past the end of the capture buffer
    for (int k = 0; k < 16; k++) capModel[(60 + k) % CAP_DEPTH] = plantKey[k];
    loadCap();
    runScan(58, 4, 8, 1'b0, 32'h0, 0, 1'b0, "R6 wrap");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule